// File: doc/BRIEF.md
# NAND Flash Host Bus Controller

This block sits between a processor's register bus and a raw 8-bit NAND flash device. It has no command sequencer. Software shapes each NAND bus cycle itself: it sets the command-latch, address-latch and chip-enable levels through a mode register. Each access to the data port then produces exactly one timed strobe on the flash. A write strobes the write line with the low byte of the bus word. A read strobes the read line and returns the byte the flash presents.

The strobe low time and the data hold time that follows come from a timing register, and each count carries a fixed offset. A data-port access holds the bus in a wait state until the strobe and its hold time have finished. All other register accesses complete in the cycle they are presented. The flash ready/busy line is synchronised and shown in a status bit. The busy-to-ready transition latches a maskable interrupt flag. A self-clearing soft reset returns the register state to its power-up values.

Bus words are 32 bits wide and registers sit on 4-byte offsets: data 0x00, mode 0x04, status 0x08, interrupt flag 0x0C, interrupt mask 0x10, timing 0x14, soft reset 0x18.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset the mode, status, interrupt flag, interrupt mask and soft-reset registers read 0, the timing register reads 0x24 (hold 2, width 4), every chip-enable output is high and both strobes are high.
- R2: Mode bit 0 drives the command-latch output and bit 1 drives the address-latch output. Bits 3:2 pick chip-enable line 0 to 3, and only that line goes low, and only while mode bit 4 is 1. With bit 4 at 0 all four lines are high.
- R3: A data-port write while mode bit 7 (write gate) is 1 drives the write strobe low for SPW+1 clocks, where SPW is timing bits 3:0. It drives the low byte with output enable high during the strobe. A data-port write with the gate at 0 produces no strobe and completes at once.
- R4: A data-port read drives the read strobe low for SPW+1 clocks and returns, in bits 7:0 of the read data, the flash byte sampled in the last low clock.
- R5: After the strobe rises, the access is acknowledged HOLD+2 clocks later, where HOLD is timing bits 7:4. The acknowledge lasts one clock.
- R6: A timing field written as 0 acts as 1. The register still reads back the value written.
- R7: Status bit 7 reads 1 while the ready/busy input is low, and it sees that input through a two-flop synchroniser. A change made just before an access is not yet visible in that access.
- R8: Interrupt flag bit 0 is set when the synchronised ready/busy input goes from low to high, and writing 1 to it clears it. The interrupt output is the flag ANDed with mask bit 0.
- R9: Writing 1 to soft-reset bit 0 makes that bit read 1 for 4 clocks, after which it clears by itself. Mode, timing, flag and mask return to their R1 values, and register writes made during that time are ignored.
- R10: Non-data registers are acknowledged in the cycle of the request. Offset 0x1C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | Access completes at the next rising edge |
| irq | output | 1 | Masked ready interrupt |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 4 | Active-low chip enables |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_re_n | output | 1 | Active-low read strobe |
| nf_dq_out | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench measures strobe width and hold length at the extremes of the timing fields: 0, 1 and 15. A design that drops an offset, or that treats 0 literally, comes out one or two clocks short, or hangs. It checks that a gated-off data write leaves the write strobe idle, since a missing gate check would corrupt the flash. It probes the synchroniser latency and the busy-to-ready edge, which a design with the wrong number of flops, or one that sets the flag on the level, would get wrong. It writes to registers during a soft reset to expose a design that lets those writes land.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int CS_W = 2;
    localparam int NCS  = 1 << CS_W;

    typedef enum logic [2:0] {
        RA_DATA = 3'd0,
        RA_MODE = 3'd1,
        RA_STAT = 3'd2,
        RA_FLAG = 3'd3,
        RA_MASK = 3'd4,
        RA_TIME = 3'd5,
        RA_SRST = 3'd6,
        RA_NONE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic            wgate;
        logic [1:0]      rsvd;
        logic            ce_on;
        logic [CS_W-1:0] cs;
        logic            ale;
        logic            cle;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_HOLD,
        ST_DONE
    } strobe_st_e;

    function automatic mode_t mode_from_byte(input logic [7:0] b);
        mode_t m;
        m      = mode_t'(b);
        m.rsvd = 2'b00;
        return m;
    endfunction

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    output logic rb_sync,
    output logic ready_edge
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= rb_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], rb_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign rb_sync    = chain[STAGES-1];
    assign ready_edge = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
    import nfc_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_read,
    input  logic [TW-1:0] spw,
    input  logic [TW-1:0] hold,
    input  logic [7:0]    wbyte,
    input  logic [7:0]    dq_in,
    output logic          we_n,
    output logic          re_n,
    output logic          dq_oe,
    output logic [7:0]    dq_out,
    output logic [7:0]    rbyte,
    output logic          active,
    output logic          done
);
    localparam int CW = TW + 1;

    strobe_st_e    st;
    logic [CW-1:0] cnt;
    logic          rd;
    logic [7:0]    wreg;
    logic [TW-1:0] spw_eff, hold_eff;

    // a zero count is taken as one
    assign spw_eff  = (spw  == '0) ? TW'(1) : spw;
    assign hold_eff = (hold == '0) ? TW'(1) : hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            rd    <= 1'b0;
            wreg  <= '0;
            rbyte <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_PULSE;
                    cnt  <= {1'b0, spw_eff};
                    rd   <= is_read;
                    wreg <= wbyte;
                end
                ST_PULSE: begin
                    if (cnt == '0) begin
                        st  <= ST_HOLD;
                        cnt <= {1'b0, hold_eff} + CW'(1);
                        if (rd) rbyte <= dq_in;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) st <= ST_DONE;
                    else           cnt <= cnt - CW'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign active = (st == ST_PULSE) || (st == ST_HOLD);
    assign done   = (st == ST_DONE);
    assign we_n   = ~((st == ST_PULSE) && !rd);
    assign re_n   = ~((st == ST_PULSE) && rd);
    assign dq_oe  = active && !rd;
    assign dq_out = wreg;

    assert_pulse_to_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PULSE) |=> (st == ST_PULSE) || (st == ST_HOLD));
    assert_done_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE) |-> $past(st == ST_HOLD));

endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
    import nfc_pkg::*;
#(
    parameter int          TW          = 4,
    parameter int          RST_CYCLES  = 4,
    parameter logic [3:0]  DEF_HOLD    = 4'd2,
    parameter logic [3:0]  DEF_SPW     = 4'd4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [4:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_ack,
    output logic          irq,
    input  logic          st_active,
    input  logic          st_done,
    input  logic [7:0]    st_rbyte,
    input  logic          rb_sync,
    input  logic          ready_edge,
    output mode_t         mode,
    output logic [TW-1:0] spw,
    output logic [TW-1:0] hold,
    output logic          st_start,
    output logic          st_read,
    output logic [7:0]    st_wbyte,
    output logic          soft_rst
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    reg_idx_e         idx;
    logic             is_data, wr_blocked, wen;
    logic             flag_q, mask_q;
    logic [2*TW-1:0]  time_q;
    logic [RCW-1:0]   rcnt;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};
    assign idx         = reg_idx_e'(bus_addr[4:2]);
    assign is_data     = (idx == RA_DATA);
    assign wr_blocked  = bus_wr && !mode.wgate;
    assign wen         = bus_req && bus_wr && !is_data;
    assign soft_rst    = (rcnt != '0);

    assign st_start = bus_req && is_data && !wr_blocked && !st_active && !st_done && !soft_rst;
    assign st_read  = !bus_wr;
    assign st_wbyte = bus_wdata[7:0];
    assign bus_ack  = bus_req && (is_data ? (wr_blocked || st_done) : 1'b1);

    assign spw  = time_q[TW-1:0];
    assign hold = time_q[2*TW-1:TW];
    assign irq  = flag_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst)                                              rcnt <= '0;
        else if (soft_rst)                                    rcnt <= rcnt - RCW'(1);
        else if (wen && idx == RA_SRST && bus_wdata[0])       rcnt <= RCW'(RST_CYCLES);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            mode   <= '0;
            time_q <= {TW'(DEF_HOLD), TW'(DEF_SPW)};
            flag_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (wen && idx == RA_MODE) mode   <= mode_from_byte(bus_wdata[7:0]);
            if (wen && idx == RA_TIME) time_q <= bus_wdata[2*TW-1:0];
            if (wen && idx == RA_MASK) mask_q <= bus_wdata[0];
            if (ready_edge)                                   flag_q <= 1'b1;
            else if (wen && idx == RA_FLAG && bus_wdata[0])   flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            RA_DATA: bus_rdata[7:0]      = st_rbyte;
            RA_MODE: bus_rdata[7:0]      = mode;
            RA_STAT: bus_rdata[7]        = ~rb_sync | st_active;
            RA_FLAG: bus_rdata[0]        = flag_q;
            RA_MASK: bus_rdata[0]        = mask_q;
            RA_TIME: bus_rdata[2*TW-1:0] = time_q;
            RA_SRST: bus_rdata[0]        = soft_rst;
            default: bus_rdata           = '0;
        endcase
    end

    assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ready_edge));
    assert_srst_clears_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (mode == '0) && (mask_q == 1'b0));

endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
    import nfc_pkg::*;
#(
    parameter int          TW         = 4,
    parameter int          SYNC_STG   = 2,
    parameter int          RST_CYCLES = 4,
    parameter logic [3:0]  DEF_HOLD   = 4'd2,
    parameter logic [3:0]  DEF_SPW    = 4'd4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        irq,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic [3:0]  nf_ce_n,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_out,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_in,
    input  logic        nf_rb
);
    mode_t         mode;
    logic [TW-1:0] spw, hold;
    logic          st_start, st_read, st_active, st_done, soft_rst;
    logic [7:0]    st_wbyte, st_rbyte;
    logic          rb_sync, ready_edge;

    nfc_rb_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .rb_async(nf_rb),
        .rb_sync(rb_sync), .ready_edge(ready_edge)
    );

    nfc_regs #(.TW(TW), .RST_CYCLES(RST_CYCLES), .DEF_HOLD(DEF_HOLD), .DEF_SPW(DEF_SPW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq),
        .st_active(st_active), .st_done(st_done), .st_rbyte(st_rbyte),
        .rb_sync(rb_sync), .ready_edge(ready_edge),
        .mode(mode), .spw(spw), .hold(hold),
        .st_start(st_start), .st_read(st_read), .st_wbyte(st_wbyte), .soft_rst(soft_rst)
    );

    nfc_strobe #(.TW(TW)) u_strobe (
        .clk(clk), .rst(rst | soft_rst),
        .start(st_start), .is_read(st_read), .spw(spw), .hold(hold),
        .wbyte(st_wbyte), .dq_in(nf_dq_in),
        .we_n(nf_we_n), .re_n(nf_re_n), .dq_oe(nf_dq_oe), .dq_out(nf_dq_out),
        .rbyte(st_rbyte), .active(st_active), .done(st_done)
    );

    assign nf_cle = mode.cle;
    assign nf_ale = mode.ale;

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_ce
            assign nf_ce_n[i] = ~(mode.ce_on && (mode.cs == CS_W'(i)));
        end
    endgenerate

    assert_we_gated_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(nf_we_n) |-> mode.wgate);
    assert_one_ce_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nf_ce_n));

endmodule

// File: tb/tb_nand_host_ctrl.sv
module tb_nand_host_ctrl;
    logic        clk = 0, rst = 1;
    logic        bus_req = 0, bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        bus_ack, irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [3:0]  nf_ce_n;
    logic [7:0]  nf_dq_out, nf_dq_in = 8'h00;
    logic        nf_rb = 1;

    int n_chk = 0, n_bad = 0;
    int cur_low = 0, last_w = 0, hold_cnt = 0, last_h = 0, pulses = 0;
    bit hold_on = 0;
    logic [7:0] seen_dq = 0;
    logic       seen_oe = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    nand_host_ctrl dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // strobe width / hold monitor
    always @(negedge clk) begin
        if (!(nf_we_n && nf_re_n)) begin
            if (cur_low == 0) pulses++;
            cur_low++;
            if (!nf_we_n) begin seen_dq = nf_dq_out; seen_oe = nf_dq_oe; end
        end else if (cur_low > 0) begin
            last_w = cur_low; cur_low = 0; hold_on = 1; hold_cnt = 1;
        end else if (hold_on) begin
            if (bus_ack) begin last_h = hold_cnt; hold_on = 0; end
            else hold_cnt++;
        end
    end

    // scoreboard monitor for reads
    always @(negedge clk) begin
        #2;
        if (bus_req && bus_ack && !bus_wr) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata == e, t, bus_rdata, e);
        end
    end

    task automatic access(input bit wr, input logic [4:0] a, input logic [31:0] d, output int waits);
        @(negedge clk);
        bus_req = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        waits = 0;
        forever begin
            #1;
            if (bus_ack) break;
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        int w;
        access(1, a, d, w);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        int w;
        exp_q.push_back(e); tag_q.push_back(tag);
        access(0, a, 0, w);
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int w, p0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(nf_ce_n == 4'hF && nf_we_n && nf_re_n, "R1 pins", {nf_ce_n, nf_we_n, nf_re_n}, 'h3F);
        rd(5'h04, 0, "R1 mode");  rd(5'h08, 0, "R1 status");
        rd(5'h0C, 0, "R1 flag");  rd(5'h10, 0, "R1 mask");
        rd(5'h14, 32'h24, "R1 timing"); rd(5'h18, 0, "R1 srst");
        // R2 mode pins
        wr(5'h04, 32'h03);
        check(nf_cle && nf_ale && nf_ce_n == 4'hF, "R2 cle/ale", {nf_cle, nf_ale, nf_ce_n}, 'h3F);
        wr(5'h04, 32'h18);
        check(nf_ce_n == 4'b1011 && !nf_cle, "R2 cs2", nf_ce_n, 4'b1011);
        wr(5'h04, 32'h1C);
        check(nf_ce_n == 4'b0111, "R2 cs3", nf_ce_n, 4'b0111);
        wr(5'h04, 32'h0C);
        check(nf_ce_n == 4'hF, "R2 ce off", nf_ce_n, 4'hF);
        // R3 gated write
        wr(5'h04, 32'h10);
        p0 = pulses;
        access(1, 5'h00, 32'h77, w);
        check(w == 0, "R3 gated ack", w, 0);
        repeat (3) @(negedge clk);
        check(pulses == p0 && nf_we_n, "R3 no strobe", pulses, p0);
        // R3/R5 default timing write
        wr(5'h04, 32'h90);
        access(1, 5'h00, 32'h1234_AB5A, w);
        check(last_w == 5, "R3 we width", last_w, 5);
        check(seen_dq == 8'h5A && seen_oe, "R3 data", seen_dq, 8'h5A);
        check(last_h == 4, "R5 hold default", last_h, 4);
        check(w == 10, "R5 total wait", w, 10);
        // R4 read, spw1 hold3
        wr(5'h14, 32'h31);
        nf_dq_in = 8'hC3;
        rd(5'h00, 32'hC3, "R4 read data");
        check(last_w == 2, "R4 re width", last_w, 2);
        check(last_h == 5, "R5 hold 3", last_h, 5);
        // R6 zero fields
        wr(5'h14, 32'h00);
        rd(5'h14, 32'h00, "R6 readback");
        access(1, 5'h00, 32'h11, w);
        check(last_w == 2, "R6 width zero", last_w, 2);
        check(last_h == 3, "R6 hold zero", last_h, 3);
        // maximum fields
        wr(5'h14, 32'hFF);
        nf_dq_in = 8'h3E;
        rd(5'h00, 32'h3E, "R4 read max");
        check(last_w == 16, "R4 width max", last_w, 16);
        check(last_h == 17, "R5 hold max", last_h, 17);
        // R7 busy sync, R8 flag
        @(negedge clk); nf_rb = 0;
        rd(5'h08, 32'h00, "R7 latency");
        repeat (2) @(negedge clk);
        rd(5'h08, 32'h80, "R7 busy");
        rd(5'h0C, 32'h00, "R8 no flag on busy");
        nf_rb = 1;
        repeat (4) @(negedge clk);
        rd(5'h08, 32'h00, "R7 ready");
        rd(5'h0C, 32'h01, "R8 flag set");
        check(irq == 0, "R8 masked", irq, 0);
        wr(5'h10, 32'h1);
        check(irq == 1, "R8 unmasked", irq, 1);
        wr(5'h0C, 32'h1);
        check(irq == 0, "R8 w1c irq", irq, 0);
        rd(5'h0C, 32'h00, "R8 w1c");
        // R9 soft reset
        wr(5'h04, 32'h93); wr(5'h14, 32'h57);
        wr(5'h18, 32'h1);
        rd(5'h18, 32'h1, "R9 busy bit");
        wr(5'h04, 32'h03);
        repeat (4) @(negedge clk);
        rd(5'h18, 32'h0, "R9 self clear");
        rd(5'h04, 32'h0, "R9 mode cleared");
        rd(5'h14, 32'h24, "R9 timing default");
        rd(5'h10, 32'h0, "R9 mask cleared");
        check(!nf_cle && nf_ce_n == 4'hF, "R9 pins", {nf_cle, nf_ce_n}, 'h0F);
        // R10 unmapped and single-cycle ack
        rd(5'h1C, 32'h0, "R10 unmapped");
        access(0, 5'h10, 0, w);
        exp_q.push_back(0); tag_q.push_back("R10 dummy");
        check(w == 0, "R10 ack same cycle", w, 0);
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule